// File: doc/BRIEF.md
# H-Bridge Drive Mode Decoder

This block turns two control bits into gate commands for the two half-bridges of a full H-bridge motor stage. Each half-bridge (leg) is commanded to one of three states: high side on, low side on, or both off (floating). A two-bit drive-mode register chooses how the two control bits are read: a direction/enable scheme, a paired PWM scheme, an independent scheme where each bit owns one leg, or a forced-off code that ignores the control bits entirely.

The two control bits come either from external pins or from two register-held bits, picked by a source-select input. In independent mode a per-leg disable input floats the chosen leg. A shutdown input from the fault supervisor overrides everything and turns all four switches off. All outputs are registered, so a command is seen at the gates one clock after its inputs are sampled. Dead time, slew control and current chopping are done downstream.

Top module: `hbridge_mode_dec`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four outputs are 0 after that edge and the drive mode register is set to 01 (paired PWM); with no later load the block behaves as in R3.
- R2: Mode 00 (direction/enable), with ctrl bit 0 as enable and bit 1 as direction: enable 0 turns on both low sides; enable 1 with direction 1 gives leg 0 high and leg 1 low; enable 1 with direction 0 gives leg 0 low and leg 1 high.
- R3: Mode 01 (paired PWM), with ctrl bit 0 and bit 1 as the two inputs: 00 floats both legs; 11 turns on both low sides; bit0=1,bit1=0 gives leg 0 high and leg 1 low; bit0=0,bit1=1 gives leg 0 low and leg 1 high.
- R4: Mode 10 (independent): leg i is driven high when ctrl bit i is 1 and low when it is 0.
- R5: Mode 11 floats both legs whatever the control bits are.
- R6: With `src_sel` 0 the control bits are `pin_ctrl`; with `src_sel` 1 they are `reg_ctrl`, and the unselected pair has no effect on the outputs.
- R7: In mode 10, `leg_dis[i]` = 1 floats leg i; in every other mode `leg_dis` has no effect on the outputs.
- R8: The high-side and low-side enables of one leg are never both 1.
- R9: `shutdown` = 1 turns all four outputs off one clock later, over every mode and input.
- R10: Outputs follow inputs sampled at the previous clock edge; a mode written with `mode_load` at one edge governs the outputs from the next edge on, and the mode register changes only on `mode_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_load | input | 1 | Write strobe for the drive mode register |
| mode_wdata | input | 2 | Drive mode code written on `mode_load` |
| src_sel | input | 1 | 0 selects `pin_ctrl`, 1 selects `reg_ctrl` |
| pin_ctrl | input | 2 | Control bits from external pins |
| reg_ctrl | input | 2 | Control bits from the register file |
| leg_dis | input | 2 | Per-leg float request, honoured in mode 10 only |
| shutdown | input | 1 | Fault supervisor kill, all switches off |
| hs_en | output | 2 | High-side enable, bit i for leg i |
| ls_en | output | 2 | Low-side enable, bit i for leg i |

## Verification
On every cycle the assertions check that no leg has both switches on, that a shutdown or a mode-11 setting leaves every switch off one clock later, that an independent-mode disable floats its leg, and that the mode register only moves on a load. The truth tables of the three driving modes, the source selection, the ignoring of disables outside independent mode and the reset value of the mode register can only be shown by the bench sweeping every mode, source, control pattern, disable and shutdown combination against its reference model.

// File: rtl/hbd_pkg.sv
// Package: shared types and sizes for the H-bridge drive mode decoder.
// Assumes two legs and two control bits; the mode codes are fixed encodings.
package hbd_pkg;

    localparam int LEG_COUNT = 2;
    localparam int CTRL_W    = 2;
    localparam int MODE_W    = 2;

    typedef enum logic [MODE_W-1:0] {
        DRV_DIR_EN = 2'b00,
        DRV_PAIR   = 2'b01,
        DRV_INDEP  = 2'b10,
        DRV_OFF    = 2'b11
    } drv_mode_e;

    typedef enum logic [1:0] {
        LEG_FLOAT = 2'b00,
        LEG_HIGH  = 2'b01,
        LEG_LOW   = 2'b10
    } leg_cmd_e;

    localparam drv_mode_e MODE_RESET = DRV_PAIR;

endpackage

// File: rtl/hbd_src_mux.sv
// Module: picks the control bit pair from pins or register bits.
// Assumes both sources are already synchronous to clk.
module hbd_src_mux #(
    parameter int W = 2
) (
    input  logic         sel_reg,
    input  logic [W-1:0] pin_bits,
    input  logic [W-1:0] reg_bits,
    output logic [W-1:0] ctrl
);

    // Route the selected source to the decoder.
    always_comb begin
        ctrl = sel_reg ? reg_bits : pin_bits;
    end

endmodule

// File: rtl/hbd_mode_decode.sv
// Module: combinational map from drive mode and control bits to a per-leg
// command (float / high / low). Assumes ctrl[0] is enable or IN1 and
// ctrl[1] is direction or IN2.
module hbd_mode_decode
    import hbd_pkg::*;
(
    input  drv_mode_e              mode,
    input  logic [CTRL_W-1:0]      ctrl,
    output leg_cmd_e               cmd [LEG_COUNT]
);

    // Decode one of four drive schemes into leg commands.
    always_comb begin
        for (int i = 0; i < LEG_COUNT; i++) cmd[i] = LEG_FLOAT;
        unique case (mode)
            DRV_DIR_EN: begin
                if (!ctrl[0]) begin
                    cmd[0] = LEG_LOW;
                    cmd[1] = LEG_LOW;
                end else if (ctrl[1]) begin
                    cmd[0] = LEG_HIGH;
                    cmd[1] = LEG_LOW;
                end else begin
                    cmd[0] = LEG_LOW;
                    cmd[1] = LEG_HIGH;
                end
            end
            DRV_PAIR: begin
                unique case (ctrl)
                    2'b00: begin
                        cmd[0] = LEG_FLOAT;
                        cmd[1] = LEG_FLOAT;
                    end
                    2'b01: begin
                        cmd[0] = LEG_HIGH;
                        cmd[1] = LEG_LOW;
                    end
                    2'b10: begin
                        cmd[0] = LEG_LOW;
                        cmd[1] = LEG_HIGH;
                    end
                    default: begin
                        cmd[0] = LEG_LOW;
                        cmd[1] = LEG_LOW;
                    end
                endcase
            end
            DRV_INDEP: begin
                for (int i = 0; i < LEG_COUNT; i++)
                    cmd[i] = ctrl[i] ? LEG_HIGH : LEG_LOW;
            end
            default: begin
                for (int i = 0; i < LEG_COUNT; i++) cmd[i] = LEG_FLOAT;
            end
        endcase
    end

endmodule

// File: rtl/hbd_leg_stage.sv
// Module: output register for one leg; applies the leg disable (when the
// caller says it is honoured) and the global shutdown, then drives the
// high/low switch enables. Assumes synchronous active-low reset.
module hbd_leg_stage
    import hbd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  leg_cmd_e cmd,
    input  logic     dis_honoured,
    input  logic     dis_req,
    input  logic     shutdown,
    output logic     hs,
    output logic     ls
);

    leg_cmd_e eff_cmd;

    // Apply overrides: shutdown first, then the honoured disable.
    always_comb begin
        if (shutdown || (dis_honoured && dis_req)) eff_cmd = LEG_FLOAT;
        else                                       eff_cmd = cmd;
    end

    // Register the switch enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs <= 1'b0;
            ls <= 1'b0;
        end else begin
            hs <= (eff_cmd == LEG_HIGH);
            ls <= (eff_cmd == LEG_LOW);
        end
    end

    assert_no_shoot_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs && ls));

    assert_shutdown_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (!hs && !ls));

    assert_disable_floats_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_honoured && dis_req) |=> (!hs && !ls));

endmodule

// File: rtl/hbridge_mode_dec.sv
// Module: top of the H-bridge drive mode decoder. Holds the drive mode
// register (reset to paired PWM), selects the control source, decodes the
// mode and registers per-leg switch enables. Assumes all inputs are
// synchronous to clk; outputs lag inputs by one clock.
module hbridge_mode_dec
    import hbd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_load,
    input  logic [MODE_W-1:0]    mode_wdata,
    input  logic                 src_sel,
    input  logic [CTRL_W-1:0]    pin_ctrl,
    input  logic [CTRL_W-1:0]    reg_ctrl,
    input  logic [LEG_COUNT-1:0] leg_dis,
    input  logic                 shutdown,
    output logic [LEG_COUNT-1:0] hs_en,
    output logic [LEG_COUNT-1:0] ls_en
);

    drv_mode_e         mode_q;
    logic [CTRL_W-1:0] ctrl_sel;
    leg_cmd_e          leg_cmd [LEG_COUNT];
    logic              indep_mode;

    // Drive mode register, written by the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= MODE_RESET;
        else if (mode_load) mode_q <= drv_mode_e'(mode_wdata);
    end

    // Disables count only in independent mode.
    always_comb begin
        indep_mode = (mode_q == DRV_INDEP);
    end

    hbd_src_mux #(.W(CTRL_W)) i_src_mux (
        .sel_reg  (src_sel),
        .pin_bits (pin_ctrl),
        .reg_bits (reg_ctrl),
        .ctrl     (ctrl_sel)
    );

    hbd_mode_decode i_decode (
        .mode (mode_q),
        .ctrl (ctrl_sel),
        .cmd  (leg_cmd)
    );

    for (genvar g = 0; g < LEG_COUNT; g++) begin : g_leg
        hbd_leg_stage i_leg (
            .clk          (clk),
            .rst_n        (rst_n),
            .cmd          (leg_cmd[g]),
            .dis_honoured (indep_mode),
            .dis_req      (leg_dis[g]),
            .shutdown     (shutdown),
            .hs           (hs_en[g]),
            .ls           (ls_en[g])
        );
    end

    assert_off_mode_floats_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == DRV_OFF) |=> (hs_en == '0 && ls_en == '0));

    assert_mode_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_load |=> $stable(mode_q));

endmodule

// File: tb/test_hbridge_mode_dec.sv
// Bench: behavioural reference model compared against the outputs every clock.
module test_hbridge_mode_dec;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_load;
    logic [1:0] mode_wdata;
    logic       src_sel;
    logic [1:0] pin_ctrl, reg_ctrl, leg_dis;
    logic       shutdown;
    logic [1:0] hs_en, ls_en;

    int checks = 0;
    int errors = 0;
    int model_mode;
    bit done = 0;

    always #10 clk = ~clk;

    hbridge_mode_dec i_hbridge_mode_dec (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_wdata(mode_wdata),
        .src_sel(src_sel), .pin_ctrl(pin_ctrl), .reg_ctrl(reg_ctrl),
        .leg_dis(leg_dis), .shutdown(shutdown), .hs_en(hs_en), .ls_en(ls_en)
    );

    // Reference: returns {hs[1:0], ls[1:0]}.
    function automatic logic [3:0] ref_out(int mode, logic [1:0] c, logic [1:0] d, logic sd);
        logic [1:0] h = 2'b00, l = 2'b00;
        if (sd) return 4'b0;
        case (mode)
            0: begin
                if (!c[0])      l = 2'b11;
                else if (c[1]) begin h = 2'b01; l = 2'b10; end
                else            begin h = 2'b10; l = 2'b01; end
            end
            1: begin
                if (c == 2'b11)      l = 2'b11;
                else if (c == 2'b01) begin h = 2'b01; l = 2'b10; end
                else if (c == 2'b10) begin h = 2'b10; l = 2'b01; end
            end
            2: begin
                for (int i = 0; i < 2; i++)
                    if (!d[i]) begin
                        if (c[i]) h[i] = 1'b1; else l[i] = 1'b1;
                    end
            end
            default: ;
        endcase
        return {h, l};
    endfunction

    task automatic compare(string tag, logic [3:0] exp);
        checks++;
        if ({hs_en, ls_en} !== exp) begin
            errors++;
            $display("FAIL %s: got hs=%b ls=%b expected hs=%b ls=%b",
                     tag, hs_en, ls_en, exp[3:2], exp[1:0]);
        end
        checks++;
        if ((hs_en & ls_en) != 2'b00) begin
            errors++;
            $display("FAIL R8: got hs=%b ls=%b expected no leg with both on", hs_en, ls_en);
        end
    endtask

    // One cycle: drive at negedge, model the edge, compare at next negedge.
    task automatic step(logic ld, logic [1:0] wd, logic s, logic [1:0] p, logic [1:0] r,
                        logic [1:0] d, logic sd, string tag);
        logic [3:0] exp;
        mode_load = ld; mode_wdata = wd; src_sel = s;
        pin_ctrl = p; reg_ctrl = r; leg_dis = d; shutdown = sd;
        @(posedge clk);
        exp = ref_out(model_mode, s ? r : p, d, sd);
        if (ld) model_mode = int'(wd);
        @(negedge clk);
        compare(tag, exp);
    endtask

    function automatic string pick_tag(int m, logic [1:0] d, logic sd);
        if (sd) return "R9";
        if (d != 2'b00) return "R7";
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        rst_n = 1'b0; mode_load = 1'b1; mode_wdata = 2'b11; src_sel = 1'b0;
        pin_ctrl = 2'b11; reg_ctrl = 2'b01; leg_dis = 2'b00; shutdown = 1'b0;
        model_mode = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1", 4'b0000);
        rst_n = 1'b1;
        // R1: mode must be paired PWM with no load after reset.
        step(0, 2'b00, 0, 2'b01, 2'b00, 2'b00, 0, "R1");
        step(0, 2'b00, 0, 2'b11, 2'b00, 2'b00, 0, "R1");
        // R6: pins and register bits differ; only the selected pair counts.
        step(0, 2'b00, 1, 2'b01, 2'b10, 2'b00, 0, "R6");
        step(0, 2'b00, 0, 2'b01, 2'b10, 2'b00, 0, "R6");
        step(0, 2'b00, 1, 2'b11, 2'b00, 2'b00, 0, "R6");
        // R10: load at one edge, new mode governs the next.
        step(1, 2'b11, 0, 2'b01, 2'b00, 2'b00, 0, "R10");
        step(0, 2'b00, 0, 2'b01, 2'b00, 2'b00, 0, "R10");
        step(1, 2'b10, 0, 2'b11, 2'b00, 2'b00, 0, "R10");
        step(0, 2'b10, 0, 2'b11, 2'b00, 2'b00, 0, "R10");
        // Full sweep of mode, source, control, disable and shutdown.
        for (int m = 0; m < 4; m++) begin
            step(1, 2'(m), 0, 2'b00, 2'b00, 2'b00, 0, "R10");
            for (int s = 0; s < 2; s++)
                for (int c = 0; c < 4; c++)
                    for (int d = 0; d < 4; d++)
                        for (int sd = 0; sd < 2; sd++)
                            step(0, 2'b00, 1'(s), s ? 2'(~c) : 2'(c), s ? 2'(c) : 2'(~c),
                                 2'(d), 1'(sd), pick_tag(m, 2'(d), 1'(sd)));
        end
        // R9: shutdown over an active drive, then release.
        step(1, 2'b00, 0, 2'b11, 2'b00, 2'b00, 1, "R9");
        step(0, 2'b00, 0, 2'b11, 2'b00, 2'b00, 0, "R2");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule